// File: doc/BRIEF.md
# Variable Clock Phase-Step Controller

This block keeps the phase offset that a clock manager applies to its output, counted in steps of 1/256 of the input clock period. A delay stage downstream takes the offset as its target; the delay hardware itself lies outside the block. The offset is signed. It starts from a configured value between 0 and 255 and may never leave a symmetric window of plus or minus a configured maximum magnitude.

The user side runs entirely on its own step clock. A one-cycle request moves the offset by one unit in the direction that the direction input selects. The request is taken only when no earlier step is still pending. A step takes a fixed number of clock cycles, and then a one-cycle acknowledge pulse reports it as complete. If a step would leave the allowed window, it is refused: the acknowledge still comes, the offset stays where it is, and an error flag goes high.

A mode parameter picks one of two behaviours. In variable mode the offset moves as described above. In fixed mode the offset is frozen at its configured value and the request pins do nothing.

Top module: `phase_step_ctrl`

## Requirements
- R1: After a synchronous reset, `phase_tgt` equals INIT_PHASE, and `step_ack` and `range_err` are 0.
- R2: In variable mode, a completed step with `step_up` = 1 at acceptance raises `phase_tgt` by one unit.
- R3: In variable mode, a completed step with `step_up` = 0 at acceptance lowers `phase_tgt` by one unit.
- R4: A request is accepted at a rising edge where `step_req` = 1 and no step is pending. `step_ack` is then high for exactly one cycle, starting STEP_LAT edges after the acceptance edge. `phase_tgt` changes only on that same edge.
- R5: `step_req` is ignored from the acceptance edge up to and including the completion edge. With `step_req` held high, steps therefore complete every STEP_LAT+1 cycles.
- R6: A step that would take `phase_tgt` above MAX_MAG or below -MAX_MAG is refused. It is still acknowledged, the phase stays unchanged, and `range_err` is set. `phase_tgt` always lies within plus or minus MAX_MAG.
- R7: `range_err` reflects the outcome of the last completed step. A completed step that stays within range clears it, and reset clears it.
- R8: In fixed mode, `phase_tgt` stays at INIT_PHASE, `step_ack` stays 0 and `range_err` stays 0, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| step_clk | input | 1 | Clock of the step interface |
| rst | input | 1 | Synchronous active-high reset |
| step_req | input | 1 | Request one phase step |
| step_up | input | 1 | Step direction: 1 raises, 0 lowers |
| phase_tgt | output | PH_W | Signed phase offset in 1/256-period units |
| step_ack | output | 1 | One-cycle pulse when a step completes |
| range_err | output | 1 | Last completed step was refused at the limit |

## Verification
The hardest situation to reach is a refused step at the negative limit that follows a long run of accepted steps while the request stays high. Reaching it needs many back-to-back steps, each paced by the busy window. The stimulus uses a small window and holds the request high far longer than the window needs. The phase therefore sweeps from the positive limit to the negative one and keeps getting refused there. The stimulus also sends extra request pulses during a pending step, and asserts reset in the middle of a step.

// File: rtl/ps_pkg.sv
package ps_pkg;

    typedef enum logic {
        MODE_FIXED    = 1'b0,
        MODE_VARIABLE = 1'b1
    } ps_mode_e;

    // step command handed from the sequencer to the accumulator
    typedef struct packed {
        logic valid;
        logic up;
    } ps_step_t;

    localparam int PS_UNITS_PER_PERIOD = 256;

    // signed width able to hold both the start value and +/- limit
    function automatic int ps_phase_width(input int max_mag);
        int big;
        big = (max_mag > PS_UNITS_PER_PERIOD - 1) ? max_mag : PS_UNITS_PER_PERIOD - 1;
        return $clog2(big + 1) + 1;
    endfunction

    function automatic logic ps_can_step(input int cur, input logic up, input int lim);
        return up ? (cur < lim) : (cur > -lim);
    endfunction

    function automatic int ps_next(input int cur, input logic up);
        return up ? cur + 1 : cur - 1;
    endfunction

endpackage

// File: rtl/ps_step_seq.sv
module ps_step_seq
    import ps_pkg::*;
#(
    parameter int STEP_LAT = 4,
    localparam int CW = $clog2(STEP_LAT + 1)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  logic     up,
    output ps_step_t fire,
    output logic     busy
);

    logic [CW-1:0] cnt;
    logic          dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            dir  <= 1'b0;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end else if (req) begin
            busy <= 1'b1;
            cnt  <= CW'(STEP_LAT - 1);
            dir  <= up;
        end
    end

    always_comb begin
        fire.valid = busy && (cnt == '0);
        fire.up    = dir;
    end

    // R4: latency counter walks down one per cycle while pending
    p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - CW'(1)));

    // R5: an idle request is taken with its direction
    p_idle_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && req) |=> (busy && dir == $past(up)));

    // R5: a request during a pending step leaves the direction alone
    p_busy_ignores_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && req) |=> (dir == $past(dir)));

endmodule

// File: rtl/ps_phase_acc.sv
module ps_phase_acc
    import ps_pkg::*;
#(
    parameter int PH_W       = 9,
    parameter int INIT_PHASE = 0,
    parameter int MAX_MAG    = 255
) (
    input  logic                   clk,
    input  logic                   rst,
    input  ps_step_t               fire,
    output logic signed [PH_W-1:0] phase_q,
    output logic                   ack_q,
    output logic                   err_q
);

    int cur;
    int nxt;
    logic ok;

    always_comb begin
        cur = int'(phase_q);
        ok  = ps_can_step(cur, fire.up, MAX_MAG);
        nxt = ps_next(cur, fire.up);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_W'(INIT_PHASE);
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            ack_q <= fire.valid;
            if (fire.valid) begin
                if (ok) begin
                    phase_q <= PH_W'(nxt);
                    err_q   <= 1'b0;
                end else begin
                    err_q   <= 1'b1;
                end
            end
        end
    end

    // R4: the phase moves only on an acknowledged completion
    p_move_needs_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && phase_q != $past(phase_q)) |-> ack_q);

    // R4: acknowledge is a single-cycle pulse
    p_single_ack_r4: assert property (@(posedge clk) disable iff (rst)
        ack_q |=> !ack_q);

    // R6: the offset never leaves the allowed window
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (int'(phase_q) <= MAX_MAG) && (int'(phase_q) >= -MAX_MAG));

    // R7: the error flag changes only with a completion
    p_err_with_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && err_q != $past(err_q)) |-> ack_q);

endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
    import ps_pkg::*;
#(
    parameter ps_mode_e MODE       = MODE_VARIABLE,
    parameter int       INIT_PHASE = 0,
    parameter int       MAX_MAG    = 255,
    parameter int       STEP_LAT   = 4,
    localparam int      PH_W       = ps_phase_width(MAX_MAG)
) (
    input  logic                   step_clk,
    input  logic                   rst,
    input  logic                   step_req,
    input  logic                   step_up,
    output logic signed [PH_W-1:0] phase_tgt,
    output logic                   step_ack,
    output logic                   range_err
);

    ps_step_t fire;
    logic     busy;

    generate
        if (MODE == MODE_VARIABLE) begin : g_var
            ps_step_seq #(
                .STEP_LAT (STEP_LAT)
            ) u_seq (
                .clk  (step_clk),
                .rst  (rst),
                .req  (step_req),
                .up   (step_up),
                .fire (fire),
                .busy (busy)
            );
        end else begin : g_fix
            assign fire = '0;
            assign busy = 1'b0;

            // R8: frozen offset, no acknowledge, no error
            p_fixed_frozen_r8: assert property (@(posedge step_clk) disable iff (rst)
                (phase_tgt == PH_W'(INIT_PHASE)) && !step_ack && !range_err);
        end
    endgenerate

    ps_phase_acc #(
        .PH_W       (PH_W),
        .INIT_PHASE (INIT_PHASE),
        .MAX_MAG    (MAX_MAG)
    ) u_acc (
        .clk     (step_clk),
        .rst     (rst),
        .fire    (fire),
        .phase_q (phase_tgt),
        .ack_q   (step_ack),
        .err_q   (range_err)
    );

    // R5: a completion only happens while a step is pending
    p_ack_after_busy_r5: assert property (@(posedge step_clk) disable iff (rst)
        (!$past(rst) && step_ack) |-> $past(busy));

endmodule

// File: tb/test_phase_step_ctrl.sv
`timescale 1ns/1ps
module test_phase_step_ctrl;
    import ps_pkg::*;

    localparam int INIT_V = 5;
    localparam int MAX_V  = 8;
    localparam int LAT    = 4;
    localparam int INIT_F = 200;
    localparam int PW     = ps_phase_width(MAX_V);
    localparam int PWF    = ps_phase_width(255);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0;
    logic up  = 1'b0;

    logic signed [PW-1:0]  ph_v;
    logic                  ack_v, err_v;
    logic signed [PWF-1:0] ph_f;
    logic                  ack_f, err_f;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    phase_step_ctrl #(
        .MODE(MODE_VARIABLE), .INIT_PHASE(INIT_V), .MAX_MAG(MAX_V), .STEP_LAT(LAT)
    ) i_phase_step_ctrl (
        .step_clk(clk), .rst(rst), .step_req(req), .step_up(up),
        .phase_tgt(ph_v), .step_ack(ack_v), .range_err(err_v)
    );

    phase_step_ctrl #(
        .MODE(MODE_FIXED), .INIT_PHASE(INIT_F), .MAX_MAG(255), .STEP_LAT(LAT)
    ) i_phase_step_ctrl_fix (
        .step_clk(clk), .rst(rst), .step_req(req), .step_up(up),
        .phase_tgt(ph_f), .step_ack(ack_f), .range_err(err_f)
    );

    // behavioural reference
    int m_phase, m_due;
    bit m_ack, m_err, m_busy, m_dir, started;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = INIT_V; m_err = 0; m_ack = 0; m_busy = 0; m_due = 0;
        end else begin
            m_ack = 0;
            if (m_busy) begin
                m_due = m_due - 1;
                if (m_due == 0) begin
                    m_busy = 0;
                    m_ack  = 1;
                    if (m_dir ? (m_phase + 1 <= MAX_V) : (m_phase - 1 >= -MAX_V)) begin
                        m_phase = m_dir ? m_phase + 1 : m_phase - 1;
                        m_err   = 0;
                    end else begin
                        m_err = 1;
                    end
                end
            end else if (req) begin
                m_busy = 1; m_due = LAT; m_dir = up;
            end
        end
        started = 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("R2,R3,R6 phase", int'(ph_v), m_phase);
            chk("R4,R5 ack", int'(ack_v), int'(m_ack));
            chk("R6,R7 error", int'(err_v), int'(m_err));
            chk("R8 fixed phase", int'(ph_f), INIT_F);
            chk("R8 fixed ack", int'(ack_f), 0);
            chk("R8 fixed error", int'(err_f), 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit dir);
        @(negedge clk); req = 1'b1; up = dir;
        @(negedge clk); req = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        // R1: reset values
        chk("R1 reset phase", int'(ph_v), INIT_V);
        chk("R1 reset ack", int'(ack_v), 0);
        chk("R1 reset error", int'(err_v), 0);

        // R2: three raises up to the limit
        for (int i = 0; i < 3; i++) begin pulse(1'b1); cyc(LAT + 2); end
        chk("R2 at limit", int'(ph_v), MAX_V);
        // R6: refused raise at the limit
        pulse(1'b1); cyc(LAT + 2);
        chk("R6 refused keeps phase", int'(ph_v), MAX_V);
        chk("R6 refused sets error", int'(err_v), 1);
        // R3, R7: a lowering step clears the error
        pulse(1'b0); cyc(LAT + 2);
        chk("R3 lowered", int'(ph_v), MAX_V - 1);
        chk("R7 error cleared", int'(err_v), 0);

        // R5: request held high sweeps to the negative limit and beyond
        @(negedge clk); req = 1'b1; up = 1'b0;
        cyc(20 * (LAT + 1));
        req = 1'b0;
        cyc(LAT + 2);
        chk("R6 negative limit", int'(ph_v), -MAX_V);
        chk("R6 negative refusal", int'(err_v), 1);

        // R5: extra pulses during a pending step are dropped
        pulse(1'b1); cyc(1); pulse(1'b1); cyc(LAT + 4);
        chk("R5 single step taken", int'(ph_v), -MAX_V + 1);

        // back-to-back requests
        for (int i = 0; i < 4; i++) begin pulse(1'b1); cyc(LAT - 1); end
        cyc(LAT + 2);

        // R1, R7: reset in the middle of a step
        pulse(1'b0); cyc(1);
        rst = 1'b1; cyc(2); rst = 1'b0;
        chk("R1 mid-step reset phase", int'(ph_v), INIT_V);
        chk("R7 reset clears error", int'(err_v), 0);
        cyc(LAT + 3);
        chk("R4 no stale ack", int'(ack_v), 0);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..all: actual 20000 cycles expected fewer");
        summary();
    end

endmodule